// File: doc/BRIEF.md
# In-band receive flow controller

This block watches the occupancy of a UART receive FIFO and decides when the transmitter must slip an in-band stop character (XOFF) or resume character (XON) into the outgoing stream so that the remote sender is throttled before the FIFO overflows. It holds a two-state view of the link, flowing or stopped. Because of that view, one threshold crossing yields exactly one character request, however long the level stays past the mark.

Two threshold schemes are offered. In enhanced mode the upper and lower marks are programmed independently: XOFF fires when the level reaches the upper mark, and XON fires when the level drops strictly below the lower mark. In legacy mode a two-bit trigger field selects a fixed upper level. XOFF fires when the level exceeds it, and XON fires on a FIFO read that leaves the level at or below half of that upper level.

The character request is a valid/ready stream towards the transmitter. Once `req_valid` is raised, it and `req_xoff` are held until a cycle with `req_ready` high completes the transfer. The one exception is cancellation: if the opposite condition arises before the transfer, the request is withdrawn rather than sent. The transmitter may hold `req_ready` low for any number of cycles.

Top module: `xonxoff_rx_flow`

## Requirements
- R1: After reset, `req_valid` is 0 and `remote_stopped` is 0, and the link is in the flowing state.
- R2: In enhanced mode (`enh_mode`=1), while flowing, a level at or above `hi_mark` raises `req_valid` with `req_xoff`=1 on the next cycle; a level of `hi_mark`-1 raises nothing.
- R3: In enhanced mode, while stopped, a level strictly below `lo_mark` raises `req_valid` with `req_xoff`=0 on the next cycle; a level equal to `lo_mark` raises nothing.
- R4: In enhanced mode a `lo_mark` of 0 is illegal and disables flow control: no request is raised, and the block returns to flowing with `remote_stopped`=0.
- R5: In legacy mode (`enh_mode`=0) the upper level is selected by `legacy_trig` for FIFO depth D=128: 0 gives 1, 1 gives D/4, 2 gives D/2, 3 gives D-D/8. XOFF is requested when the level is strictly greater than this upper level.
- R6: In legacy mode, while stopped, XON is requested only after a cycle with `rx_rd`=1 and a level at or below half the upper level (rounded down); a low level without a read raises nothing.
- R7: Flow control is active only when `fc_mode` is non-zero. With `fc_mode`=0 no request is raised, and on the next cycle the block is flowing with `remote_stopped`=0.
- R8: While `req_valid`=1 and `req_ready`=0, `req_valid` and `req_xoff` hold their values on the next cycle unless the request is cancelled.
- R9: A pending request that is not yet accepted is cancelled when the opposite condition arises: `req_valid` drops to 0 and `remote_stopped` keeps its value.
- R10: `remote_stopped` becomes 1 after a cycle in which an XOFF request is accepted (`req_valid`=`req_ready`=1) and becomes 0 after a cycle in which an XON request is accepted.
- R11: While the level stays past the threshold that caused a request, no further request of the same kind is raised after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| rx_rd | input | 1 | Receive FIFO read strobe |
| enh_mode | input | 1 | 1 selects programmable marks, 0 selects legacy triggers |
| lo_mark | input | 7 | Enhanced lower mark (0 is illegal) |
| hi_mark | input | 7 | Enhanced upper mark |
| legacy_trig | input | 2 | Legacy upper trigger select |
| fc_mode | input | 2 | In-band send select; non-zero enables flow control |
| req_valid | output | 1 | A special character must be inserted |
| req_ready | input | 1 | Transmitter accepts the character this cycle |
| req_xoff | output | 1 | 1 requests XOFF, 0 requests XON; meaningful while `req_valid`=1 |
| remote_stopped | output | 1 | The remote has been sent XOFF and not yet XON |

## Verification
The hardest situation to reach is cancellation. It needs a request that the transmitter keeps refusing while the FIFO level swings right across both marks, in the direction opposite to the one that raised the request. A directed case holds `req_ready` low, drives the level to the upper mark and then below the lower mark. The random phase keeps `req_ready` low on about three cycles in four and lets the level jump anywhere in its range at times, so that overtaken requests occur in both directions. A bench reference model predicts every output on every cycle.

// File: rtl/xonxoff_fc_pkg.sv
package xonxoff_fc_pkg;

  typedef enum logic {
    FC_FLOWING = 1'b0,
    FC_STOPPED = 1'b1
  } fc_state_e;

  // Legacy upper trigger level for a FIFO of the given depth.
  function automatic int unsigned legacy_upper(input logic [1:0] sel,
                                               input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/xonxoff_fc_thresh.sv
module xonxoff_fc_thresh #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1),
  parameter int unsigned TH_W  = 7
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_rd,
  input  logic             enh_mode,
  input  logic [TH_W-1:0]  lo_mark,
  input  logic [TH_W-1:0]  hi_mark,
  input  logic [1:0]       legacy_trig,
  input  logic [1:0]       fc_mode,
  output logic             active,
  output logic             xoff_cond,
  output logic             xon_cond
);
  import xonxoff_fc_pkg::*;

  logic [LVL_W-1:0] lo_ext, hi_ext, leg_up, leg_lo;

  assign lo_ext = LVL_W'(lo_mark);
  assign hi_ext = LVL_W'(hi_mark);
  assign leg_up = LVL_W'(legacy_upper(legacy_trig, DEPTH));
  assign leg_lo = leg_up >> 1;

  // An illegal zero lower mark switches enhanced flow control off.
  assign active = (fc_mode != 2'b00) && !(enh_mode && (lo_mark == '0));

  always_comb begin
    if (enh_mode) begin
      xoff_cond = (rx_level >= hi_ext);
      xon_cond  = (rx_level <  lo_ext);
    end else begin
      xoff_cond = (rx_level >  leg_up);
      xon_cond  = rx_rd && (rx_level <= leg_lo);
    end
  end

endmodule

// File: rtl/xonxoff_fc_fsm.sv
module xonxoff_fc_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic xoff_cond,
  input  logic xon_cond,
  input  logic req_ready,
  output logic req_valid,
  output logic req_xoff,
  output logic remote_stopped
);
  import xonxoff_fc_pkg::*;

  fc_state_e st;
  logic      vld, kind, stopped;
  logic      go_stop, go_flow, sent, cancel;

  assign go_stop = active && (st == FC_FLOWING) && xoff_cond;
  assign go_flow = active && (st == FC_STOPPED) && xon_cond;
  assign sent    = vld && req_ready;
  // A waiting request is always of the opposite kind to a new transition.
  assign cancel  = vld && !req_ready && (go_stop || go_flow);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      st      <= FC_FLOWING;
      vld     <= 1'b0;
      kind    <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (sent) stopped <= kind;
      if (go_stop || go_flow) begin
        st <= go_stop ? FC_STOPPED : FC_FLOWING;
        if (cancel) begin
          vld <= 1'b0;
        end else begin
          vld  <= 1'b1;
          kind <= go_stop;
        end
      end else if (sent) begin
        vld <= 1'b0;
      end
    end
  end

  assign req_valid      = vld;
  assign req_xoff       = kind;
  assign remote_stopped = stopped;

  AST_XOFF_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && kind) |-> (st == FC_STOPPED)); // R2
  AST_XON_ONLY_FLOWING: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !kind) |-> (st == FC_FLOWING)); // R3
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !req_ready && active && !cancel) |=> (vld && (kind == $past(kind)))); // R8
  AST_CANCEL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && active) |=> (!vld && $stable(stopped))); // R9
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!vld && !stopped)); // R7
  AST_STOP_AFTER_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(vld && req_ready && kind)); // R10
  AST_RUN_AFTER_XON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped) |-> ($past(vld && req_ready && !kind) || !$past(active))); // R10

endmodule

// File: rtl/xonxoff_rx_flow.sv
module xonxoff_rx_flow #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1),
  parameter int unsigned TH_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_rd,
  input  logic             enh_mode,
  input  logic [TH_W-1:0]  lo_mark,
  input  logic [TH_W-1:0]  hi_mark,
  input  logic [1:0]       legacy_trig,
  input  logic [1:0]       fc_mode,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_xoff,
  output logic             remote_stopped
);

  logic active, xoff_cond, xon_cond;

  xonxoff_fc_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)) u_thresh (
    .rx_level    (rx_level),
    .rx_rd       (rx_rd),
    .enh_mode    (enh_mode),
    .lo_mark     (lo_mark),
    .hi_mark     (hi_mark),
    .legacy_trig (legacy_trig),
    .fc_mode     (fc_mode),
    .active      (active),
    .xoff_cond   (xoff_cond),
    .xon_cond    (xon_cond)
  );

  xonxoff_fc_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active),
    .xoff_cond      (xoff_cond),
    .xon_cond       (xon_cond),
    .req_ready      (req_ready),
    .req_valid      (req_valid),
    .req_xoff       (req_xoff),
    .remote_stopped (remote_stopped)
  );

  AST_ZERO_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && (lo_mark == '0)) |=> (!req_valid && !remote_stopped)); // R4
  AST_NO_REPEAT_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_xoff) |=> !(req_valid && req_xoff)); // R11

endmodule

// File: tb/xonxoff_rx_flow_tb.sv
module xonxoff_rx_flow_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_level = '0;
  logic       rx_rd = 1'b0;
  logic       enh_mode = 1'b1;
  logic [6:0] lo_mark = 7'd64;
  logic [6:0] hi_mark = 7'd100;
  logic [1:0] legacy_trig = 2'd0;
  logic [1:0] fc_mode = 2'd1;
  logic       req_ready = 1'b0;
  logic       req_valid, req_xoff, remote_stopped;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_st, m_vld, m_kind, m_stop;

  always #5ns clk = ~clk;

  xonxoff_rx_flow dut_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_rd(rx_rd),
    .enh_mode(enh_mode), .lo_mark(lo_mark), .hi_mark(hi_mark),
    .legacy_trig(legacy_trig), .fc_mode(fc_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_xoff(req_xoff), .remote_stopped(remote_stopped)
  );

  function automatic int f_upper(input logic [1:0] t);
    case (t)
      2'd0: return 1;
      2'd1: return 32;
      2'd2: return 64;
      default: return 112;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit act, xo, xn, sent;
    int lv;
    lv   = int'(rx_level);
    act  = (fc_mode != 0) && !(enh_mode && lo_mark == 0);
    if (enh_mode) begin
      xo = lv >= int'(hi_mark);
      xn = lv <  int'(lo_mark);
    end else begin
      xo = lv > f_upper(legacy_trig);
      xn = rx_rd && (lv <= f_upper(legacy_trig) / 2);
    end
    sent = m_vld && req_ready;
    if (!rst_n || !act) begin
      m_st = 0; m_vld = 0; m_kind = 0; m_stop = 0;
    end else begin
      if (sent) m_stop = m_kind;
      if ((!m_st && xo) || (m_st && xn)) begin
        if (m_vld && !req_ready) m_vld = 0;
        else begin m_vld = 1; m_kind = !m_st; end
        m_st = !m_st;
      end else if (sent) m_vld = 0;
    end
  endtask

  // one clock: model follows the edge, outputs compared 1 ns later
  task automatic step();
    @(posedge clk);
    model_edge();
    #1ns;
    chk(req_valid == m_vld, "R8 model valid", req_valid, m_vld);
    if (m_vld) chk(req_xoff == m_kind, "R2/R3 model kind", req_xoff, m_kind);
    chk(remote_stopped == m_stop, "R10 model flag", remote_stopped, m_stop);
  endtask

  task automatic lvl(input int v, input bit rd);
    rx_level = 8'(v); rx_rd = rd; step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    chk(!req_valid && !remote_stopped, "R1 reset", {req_valid, remote_stopped}, 0);

    // enhanced marks 64/100
    enh_mode = 1; lo_mark = 64; hi_mark = 100; fc_mode = 1; req_ready = 0;
    lvl(99, 0);  chk(!req_valid, "R2 below hi", req_valid, 0);
    lvl(100, 0); chk(req_valid && req_xoff, "R2 at hi", {req_valid, req_xoff}, 3);
    lvl(100, 0); chk(req_valid && req_xoff, "R8 held", {req_valid, req_xoff}, 3);
    req_ready = 1; lvl(105, 0); req_ready = 0;
    chk(!req_valid && remote_stopped, "R10 xoff sent", {req_valid, remote_stopped}, 1);
    lvl(110, 0); lvl(110, 0); chk(!req_valid, "R11 no repeat", req_valid, 0);
    lvl(64, 1);  chk(!req_valid, "R3 at lo", req_valid, 0);
    lvl(63, 0);  chk(req_valid && !req_xoff, "R3 below lo", {req_valid, req_xoff}, 2);
    req_ready = 1; lvl(40, 0); req_ready = 0;
    chk(!remote_stopped && !req_valid, "R10 xon sent", remote_stopped, 0);

    // cancellation of a refused XOFF
    lvl(100, 0); chk(req_valid && req_xoff, "R9 pending", req_valid, 1);
    lvl(50, 0);  chk(!req_valid && !remote_stopped, "R9 cancelled", {req_valid, remote_stopped}, 0);

    // zero lower mark
    lo_mark = 0; lvl(120, 0); lvl(120, 0);
    chk(!req_valid, "R4 zero lo", req_valid, 0);

    // disable while stopped
    lo_mark = 64; lvl(120, 0); req_ready = 1; lvl(120, 0); req_ready = 0;
    chk(remote_stopped, "R10 stopped", remote_stopped, 1);
    fc_mode = 0; lvl(120, 0);
    chk(!req_valid && !remote_stopped, "R7 off", {req_valid, remote_stopped}, 0);

    // legacy trigger 2 -> upper 64, lower 32
    enh_mode = 0; legacy_trig = 2; lvl(10, 0); fc_mode = 2;
    lvl(64, 0); chk(!req_valid, "R5 at upper", req_valid, 0);
    lvl(65, 0); chk(req_valid && req_xoff, "R5 above upper", {req_valid, req_xoff}, 3);
    req_ready = 1; lvl(65, 0); req_ready = 0;
    lvl(30, 0); chk(!req_valid, "R6 no read", req_valid, 0);
    lvl(33, 1); chk(!req_valid, "R6 above half", req_valid, 0);
    lvl(32, 1); chk(req_valid && !req_xoff, "R6 read down", {req_valid, req_xoff}, 2);
    req_ready = 1; lvl(0, 0);

    // legacy trigger 3 -> upper 112
    legacy_trig = 3;
    lvl(112, 0); chk(!req_valid, "R5 t3 at upper", req_valid, 0);
    lvl(113, 0); chk(req_valid && req_xoff, "R5 t3 above", {req_valid, req_xoff}, 3);

    // constrained random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      int v;
      if (i % 600 == 0) begin
        enh_mode    = $urandom_range(0, 3) != 0;
        lo_mark     = 7'($urandom_range(0, 20) == 0 ? 0 : $urandom_range(1, 90));
        hi_mark     = 7'(int'(lo_mark) + $urandom_range(1, 37));
        legacy_trig = 2'($urandom_range(0, 3));
        fc_mode     = 2'($urandom_range(0, 7) == 0 ? 0 : $urandom_range(1, 3));
      end
      v = int'(rx_level);
      if ($urandom_range(0, 15) == 0) v = $urandom_range(0, 128);
      else v = v + $urandom_range(0, 6) - 3;
      if (v < 0) v = 0;
      if (v > 128) v = 128;
      req_ready = ($urandom_range(0, 3) == 0);
      lvl(v, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule